// File: doc/BRIEF.md
# Configurable LFSR Sequence Generator

A parameterised linear feedback shift register that emits one pseudo-random bit for each enabled clock and counts the steps it has taken. The feedback polynomial is a parameter mask of exponents. The output register position is a second parameter. A live input selects the Fibonacci or the Galois structure. A seed input, sampled on load, restarts the sequence.

Two startup conventions are offered, chosen at load time. In the late convention the output is invalid until the first enabled step. In the early convention the first output bit is already presented at load. Both produce the same bit stream, with the early one a single bit ahead. A seed of all zeros would lock the register up, so such a load is refused and flagged.

Top module: `lfsr_gen`

## Requirements
- R1: While rst_ni is low, state_o equals RESET_SEED, and count_o, out_o, valid_o, fb_o and lockup_o are 0.
- R2: Bit e-1 of POLY_MASK set means exponent e is in the polynomial. Register position p (1 = left-most) is state_o bit N-p, so position 1 is the MSB and position N is bit 0. The output position is OUT_POS, which is state_o bit N-OUT_POS.
- R3: With galois_i=0, a step computes the XOR of the positions named by the exponents. All bits move one position toward position N, and that XOR enters position 1.
- R4: With galois_i=1, a step moves all bits one position toward position N. The bit that leaves position N enters position 1. It is also XORed into position e+1 for every exponent e below N in the mask.
- R5: In late startup (early_i=0 at load), each enabled step sets out_o to the OUT_POS bit of the state before the step, and sets valid_o to 1.
- R6: After a late-startup load, count_o is 0 and valid_o and out_o are 0. After the first enabled step, count_o is 1 and valid_o is 1.
- R7: After an early-startup load (early_i=1), out_o is the OUT_POS bit of the seed, valid_o is 1 and count_o is 1. Each enabled step then sets out_o to the OUT_POS bit of the new state.
- R8: After every enabled step, fb_o holds the bit that entered position 1, and so equals state_o bit N-1.
- R9: With the default primitive polynomial x^5+x^4+x^3+x^2+1, the state returns to the seed after exactly 31 steps in either structure.
- R10: A load of an all-zero seed leaves state, output, valid and count unchanged and sets lockup_o. A later load of a nonzero seed clears lockup_o.
- R11: count_o rises by one on each enabled step and stays at 2^CNT_W-1 once it has reached that value.
- R12: With en_i and load_i both low, state_o, out_o, valid_o and count_o hold. When load_i and en_i are both high, the load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load seed and startup mode |
| seed_i | input | N | Seed state, MSB is position 1 |
| en_i | input | 1 | Step enable |
| galois_i | input | 1 | 1 = Galois structure, 0 = Fibonacci |
| early_i | input | 1 | Startup convention sampled at load, 1 = early |
| state_o | output | N | Current register state |
| out_o | output | 1 | Output bit |
| valid_o | output | 1 | Output bit is valid |
| fb_o | output | 1 | Bit that entered position 1 on the last step |
| count_o | output | CNT_W | Saturating step count |
| lockup_o | output | 1 | Last load attempt carried an all-zero seed |

## Verification
The 3-bit polynomial x^3+x^2+1 from seed 111 is run through a full period in both startup conventions. This separates the one-bit lead of the early convention from the late one. The 5-bit default instance uses a non-default output position. It is compared step by step against an arithmetic model in both structures, which tells apart the tap placement, the shift direction and the output index. Full-period walks from a single set bit confirm the 31-state cycle. Hold, load-over-enable, all-zero seeds and a 300-step run probe freezing, lockup and count saturation.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;
  typedef enum logic {STRUCT_FIB = 1'b0, STRUCT_GAL = 1'b1} lfsr_struct_e;
  typedef enum logic {START_LATE = 1'b0, START_EARLY = 1'b1} lfsr_start_e;
endpackage

// File: rtl/lfsr_next.sv
module lfsr_next
  import lfsr_pkg::*;
#(
  parameter int unsigned N = 5,
  parameter logic [N-1:0] POLY_MASK = 5'b11110
) (
  input  logic [N-1:0]  st_i,
  input  lfsr_struct_e  struct_i,
  output logic [N-1:0]  nxt_o,
  output logic          fb_o
);
  // rev_mask[j] marks state bit j (position N-j) as a tap
  logic [N-1:0] rev_mask;
  logic [N-1:0] gal_nxt;
  logic         fib_fb;

  for (genvar j = 0; j < N; j++) begin : g_rev
    assign rev_mask[j] = POLY_MASK[N-1-j];
  end

  assign fib_fb = ^(st_i & rev_mask);

  assign gal_nxt[N-1] = st_i[0];
  for (genvar j = 0; j < N-1; j++) begin : g_gal
    // position N-j receives position N-j-1, XORed if exponent N-j-1 tapped
    assign gal_nxt[j] = st_i[j+1] ^ (st_i[0] & POLY_MASK[N-2-j]);
  end

  always_comb begin
    if (struct_i == STRUCT_GAL) begin
      nxt_o = gal_nxt;
      fb_o  = st_i[0];
    end else begin
      nxt_o = {fib_fb, st_i[N-1:1]};
      fb_o  = fib_fb;
    end
  end
endmodule

// File: rtl/lfsr_count.sv
module lfsr_count #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_o <= '0;
    else if (ld_i)                     cnt_o <= ld_val_i;
    else if (inc_i && cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/lfsr_gen.sv
module lfsr_gen
  import lfsr_pkg::*;
#(
  parameter int unsigned N          = 5,
  parameter logic [N-1:0] POLY_MASK = 5'b11110,
  parameter int unsigned OUT_POS    = N,
  parameter int unsigned CNT_W      = 8,
  parameter logic [N-1:0] RESET_SEED = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [N-1:0]     seed_i,
  input  logic             en_i,
  input  logic             galois_i,
  input  logic             early_i,
  output logic [N-1:0]     state_o,
  output logic             out_o,
  output logic             valid_o,
  output logic             fb_o,
  output logic [CNT_W-1:0] count_o,
  output logic             lockup_o
);
  localparam int unsigned OUT_IDX = N - OUT_POS;

  logic [N-1:0]  nxt;
  logic          nxt_fb;
  logic          zero_seed, do_load, step;
  lfsr_start_e   start_q;
  lfsr_struct_e  struct_sel;
  logic [CNT_W-1:0] ld_cnt;

  assign struct_sel = lfsr_struct_e'(galois_i);
  assign zero_seed  = load_i && (seed_i == '0);
  assign do_load    = load_i && !zero_seed;
  assign step       = en_i && !load_i;
  assign ld_cnt     = early_i ? CNT_W'(1) : '0;

  lfsr_next #(.N(N), .POLY_MASK(POLY_MASK)) u_next (
    .st_i     (state_o),
    .struct_i (struct_sel),
    .nxt_o    (nxt),
    .fb_o     (nxt_fb)
  );

  lfsr_count #(.W(CNT_W)) u_count (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (do_load),
    .ld_val_i (ld_cnt),
    .inc_i    (step),
    .cnt_o    (count_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o  <= RESET_SEED;
      out_o    <= 1'b0;
      valid_o  <= 1'b0;
      fb_o     <= 1'b0;
      lockup_o <= 1'b0;
      start_q  <= START_LATE;
    end else if (zero_seed) begin
      lockup_o <= 1'b1;
    end else if (do_load) begin
      state_o  <= seed_i;
      lockup_o <= 1'b0;
      fb_o     <= 1'b0;
      start_q  <= lfsr_start_e'(early_i);
      out_o    <= early_i ? seed_i[OUT_IDX] : 1'b0;
      valid_o  <= early_i;
    end else if (step) begin
      state_o  <= nxt;
      fb_o     <= nxt_fb;
      valid_o  <= 1'b1;
      // early convention shows the new state's bit, late the old one
      out_o    <= (start_q == START_EARLY) ? nxt[OUT_IDX] : state_o[OUT_IDX];
    end
  end
endmodule

// File: rtl/lfsr_gen_chk.sv
module lfsr_gen_chk #(
  parameter int unsigned N       = 5,
  parameter int unsigned OUT_POS = N,
  parameter int unsigned CNT_W   = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_i,
  input logic [N-1:0]     seed_i,
  input logic             en_i,
  input logic             early_i,
  input logic [N-1:0]     state_o,
  input logic             out_o,
  input logic             valid_o,
  input logic             fb_o,
  input logic [CNT_W-1:0] count_o,
  input logic             lockup_o
);
  localparam int unsigned IDX = N - OUT_POS;
  localparam logic [CNT_W-1:0] CMAX = '1;

  p_late_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && seed_i != '0 && !early_i |=> count_o == '0 && !valid_o && !out_o);

  p_early_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && seed_i != '0 && early_i |=> count_o == CNT_W'(1) && valid_o
      && out_o == $past(seed_i[IDX]));

  p_fb_msb_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !load_i |=> fb_o == state_o[N-1] && valid_o);

  p_zero_seed_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && seed_i == '0 |=> lockup_o && $stable(state_o) && $stable(count_o));

  p_saturate_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o == CMAX && !load_i |=> count_o == CMAX);

  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !load_i |=> $stable(state_o) && $stable(count_o)
      && $stable(out_o) && $stable(valid_o));

  p_load_wins_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && en_i && seed_i != '0 |=> state_o == $past(seed_i));
endmodule

bind lfsr_gen lfsr_gen_chk #(.N(N), .OUT_POS(OUT_POS), .CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .load_i   (load_i),
  .seed_i   (seed_i),
  .en_i     (en_i),
  .early_i  (early_i),
  .state_o  (state_o),
  .out_o    (out_o),
  .valid_o  (valid_o),
  .fb_o     (fb_o),
  .count_o  (count_o),
  .lockup_o (lockup_o)
);

// File: tb/lfsr_gen_test.sv
module lfsr_gen_test;
  logic clk = 0;
  logic rst_n = 0;
  logic load = 0, en = 0, gal = 0, early = 0;
  logic [4:0] seed_a = '0;
  logic [2:0] seed_b = '0;
  logic [4:0] st_a; logic out_a, val_a, fb_a, lk_a; logic [7:0] cnt_a;
  logic [2:0] st_b; logic out_b, val_b, fb_b, lk_b; logic [7:0] cnt_b;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  // 5-bit default polynomial, output taken from position 2 (state bit 3)
  lfsr_gen #(.N(5), .POLY_MASK(5'b11110), .OUT_POS(2), .CNT_W(8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .seed_i(seed_a), .en_i(en),
    .galois_i(gal), .early_i(early), .state_o(st_a), .out_o(out_a),
    .valid_o(val_a), .fb_o(fb_a), .count_o(cnt_a), .lockup_o(lk_a));

  // 3-bit x^3+x^2+1, output at position 3
  lfsr_gen #(.N(3), .POLY_MASK(3'b110), .OUT_POS(3), .CNT_W(8)) uut_b (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .seed_i(seed_b), .en_i(en),
    .galois_i(gal), .early_i(early), .state_o(st_b), .out_o(out_b),
    .valid_o(val_b), .fb_o(fb_b), .count_o(cnt_b), .lockup_o(lk_b));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  // R3: taps at positions 5,4,3,2 = state bits 0..3
  function automatic logic [4:0] m_fib(input logic [4:0] s);
    return {s[3] ^ s[2] ^ s[1] ^ s[0], s[4:1]};
  endfunction
  // R4: leaving bit into positions 1, 5, 4, 3 (bits 4, 0, 1, 2)
  function automatic logic [4:0] m_gal(input logic [4:0] s);
    return {s[0], s[4:1]} ^ {2'b00, {3{s[0]}}};
  endfunction

  task automatic do_load(input logic [4:0] sa, input logic [2:0] sb, input logic e);
    seed_a = sa; seed_b = sb; early = e; load = 1; en = 0;
    @(negedge clk);
    load = 0;
  endtask

  task automatic do_step();
    en = 1;
    @(negedge clk);
    en = 0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [4:0] m, prev;
    logic [2:0] b_states [7];
    logic       b_outs [7];
    int steps;
    b_states = '{3'b011, 3'b001, 3'b100, 3'b010, 3'b101, 3'b110, 3'b111};
    b_outs   = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};

    @(negedge clk);
    // R1 reset state
    chk_eq("R1 state", st_a, 5'b11111);
    chk_eq("R1 count", cnt_a, 0);
    chk_eq("R1 flags", {out_a, val_a, fb_a, lk_a}, 0);
    chk_eq("R1 state_b", st_b, 3'b111);
    rst_n = 1;
    @(negedge clk);

    // R6 late startup, 3-bit sequence (R3, R5, R8)
    gal = 0;
    do_load(5'b10011, 3'b111, 0);
    chk_eq("R6 count after load", cnt_b, 0);
    chk_eq("R6 valid/out after load", {val_b, out_b}, 0);
    for (int k = 0; k < 7; k++) begin
      do_step();
      chk_eq("R3 state_b", st_b, b_states[k]);
      chk_eq("R5 out_b", out_b, b_outs[k]);
      chk_eq("R6 count_b", cnt_b, k + 1);
      chk_eq("R6 valid_b", val_b, 1);
      chk_eq("R8 fb_b", fb_b, st_b[2]);
    end

    // R7 early startup: one bit ahead
    do_load(5'b10011, 3'b111, 1);
    chk_eq("R7 out at load", out_b, 1);
    chk_eq("R7 valid/count at load", {val_b, cnt_b}, {1'b1, 8'd1});
    for (int k = 0; k < 7; k++) begin
      do_step();
      chk_eq("R7 out_b ahead", out_b, b_outs[(k + 1) % 7]);
      chk_eq("R7 count_b", cnt_b, k + 2);
    end

    // R2 R3 R5 Fibonacci 5-bit vs model, output index 3
    do_load(5'b10011, 3'b101, 0);
    m = 5'b10011;
    for (int k = 0; k < 40; k++) begin
      prev = m; m = m_fib(m);
      do_step();
      chk_eq("R3 state_a fib", st_a, m);
      chk_eq("R2 out_a pos2", out_a, prev[3]);
      chk_eq("R8 fb_a fib", fb_a, m[4]);
    end

    // R4 Galois 5-bit vs model
    gal = 1;
    do_load(5'b00101, 3'b101, 0);
    m = 5'b00101;
    for (int k = 0; k < 40; k++) begin
      prev = m; m = m_gal(m);
      do_step();
      chk_eq("R4 state_a gal", st_a, m);
      chk_eq("R4 fb_a gal", fb_a, prev[0]);
      chk_eq("R5 out_a gal", out_a, prev[3]);
    end
    // R7 early with Galois, position 2 bit of new state
    do_load(5'b00101, 3'b101, 1);
    chk_eq("R7 out_a at load", out_a, 0);
    do_step();
    chk_eq("R7 out_a step", out_a, m_gal(5'b00101) >> 3 & 1);

    // R9 period in both structures
    for (int g = 0; g < 2; g++) begin
      gal = g[0];
      do_load(5'b00001, 3'b001, 0);
      steps = 0;
      do begin
        do_step();
        steps++;
      end while (st_a != 5'b00001 && steps < 64);
      chk_eq("R9 period", steps, 31);
      chk_eq("R11 count tracks steps", cnt_a, 31);
    end

    // R12 hold with enable low
    do_step(); do_step();
    m = st_a; steps = cnt_a;
    prev = {out_a, val_a, 3'b000};
    repeat (3) @(negedge clk);
    chk_eq("R12 hold state", st_a, m);
    chk_eq("R12 hold count", cnt_a, steps);
    chk_eq("R12 hold out/valid", {out_a, val_a}, prev[4:3]);
    // R12 load beats enable
    seed_a = 5'b01110; seed_b = 3'b010; early = 0; load = 1; en = 1;
    @(negedge clk);
    load = 0; en = 0;
    chk_eq("R12 load wins state", st_a, 5'b01110);
    chk_eq("R12 load wins count", cnt_a, 0);

    // R10 all-zero seed
    do_step();
    m = st_a; steps = cnt_a;
    do_load(5'b00000, 3'b000, 1);
    chk_eq("R10 lockup set", {lk_a, lk_b}, 2'b11);
    chk_eq("R10 state kept", st_a, m);
    chk_eq("R10 count kept", cnt_a, steps);
    chk_eq("R10 valid kept", val_a, 1);
    do_load(5'b00011, 3'b011, 0);
    chk_eq("R10 lockup cleared", {lk_a, lk_b}, 2'b00);
    chk_eq("R10 new seed", st_a, 5'b00011);

    // R11 saturation
    en = 1;
    repeat (254) @(negedge clk);
    chk_eq("R11 count 254", cnt_a, 254);
    @(negedge clk);
    chk_eq("R11 count 255", cnt_a, 255);
    repeat (45) @(negedge clk);
    en = 0;
    chk_eq("R11 saturated", cnt_a, 255);
    chk_eq("R11 saturated b", cnt_b, 255);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule